// File: doc/BRIEF.md
# Effective Address Calculation Unit

This unit forms the 16-bit operand address for a small 8/16-bit controller core. A request carries a 4-bit mode code, the operand bytes of the instruction and a choice of index register (X, Y or the stack pointer). The unit combines these with the current register values and returns the address, a completion pulse and a valid strobe. For the auto-step mode it also returns the new index value and a one-cycle write-back enable.

Two indirect modes first compute a pointer location. They then read a 16-bit pointer from memory, high byte first, over a byte-wide request/acknowledge read port, and return that pointer as the address. The unit accepts no new request while it is reading. Decoding, operand queueing and arithmetic on data are handled elsewhere.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `ea_valid`, `illegal`, `wb_en`, `busy` and `mem_rd_req` are low and `ea` is 0.
- R2: Mode 0000 (immediate) and mode 1100 (inherent) pulse `done` with `ea_valid` low, `wb_en` low and no memory request. Mode 0001 gives `{8'h00, opnd[7:0]}`. Mode 0010 gives `opnd` unchanged.
- R3: The index base is X for `idx_sel`=00, Y for 01 and SP for 10 or 11. Mode 0011 gives the base. Mode 0100 gives base + sign-extended `opnd[8:0]`. Mode 0101 gives base + `opnd`. All sums wrap modulo 2^16.
- R4: Mode 0111 gives base + `{8'h00, acc_a}` and mode 1000 gives base + `{8'h00, acc_b}`, with wrap.
- R5: In mode 0110, `opnd[3:0]` is a signed step (-8..+7) and `opnd[4]`=1 selects pre and 0 selects post. The new value is base + step. Pre mode returns the new value as `ea`, post mode returns the old base. In both cases `wb_en` pulses for one cycle together with `done`, with `wb_val` set to the new value and `wb_sel` set to `idx_sel`. No other mode raises `wb_en`.
- R6: Mode 1010 reads at P = base + `opnd` and mode 1011 reads at P = base + `{acc_a, acc_b}`. The unit reads byte P and then byte P+1, and returns `{byte(P), byte(P+1)}` as `ea`. `mem_rd_req` and `mem_addr` hold steady until `mem_rd_ack`. `ea_valid` rises only after the second byte has been returned.
- R7: Codes 1001, 1101, 1110 and 1111 pulse `done` and `illegal`, with `ea_valid` and `wb_en` low.
- R8: Every non-indirect request completes on the first clock edge after the `start` edge. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled on the clock edge |
| mode | input | 4 | Addressing-mode code |
| opnd | input | 16 | Operand bytes of the instruction |
| idx_sel | input | 2 | Index choice: 00 X, 01 Y, 1x SP |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| idx_sp | input | 16 | Stack pointer |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| mem_rd_req | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| mem_rd_ack | input | 1 | Read data is present this cycle |
| mem_rd_data | input | 8 | Read data byte |
| busy | output | 1 | Indirect read in progress |
| done | output | 1 | One-cycle completion pulse |
| ea_valid | output | 1 | `ea` holds a formed address this cycle |
| ea | output | 16 | Effective address |
| illegal | output | 1 | Unused mode code was requested |
| wb_en | output | 1 | Index write-back enable pulse |
| wb_sel | output | 2 | Index register to update |
| wb_val | output | 16 | New index value |

## Verification
A non-indirect request registers its result on the edge that samples `start`, so the bench checks `done`, `ea`, `illegal` and the write-back outputs at the falling edge right after that edge. With the bench memory acknowledging at once, the indirect modes take three edges. The bench samples `mem_addr` after the first edge (P) and after the second edge (P+1), and checks the result after the third. One run adds two stall cycles before the first acknowledge, which moves the result two cycles later. Another run raises `start` while the unit is busy and checks that no extra `done` appears.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [2*DW-1:0]   opnd,
  input  logic [1:0]        idx_sel,
  input  logic [2*DW-1:0]   idx_x,
  input  logic [2*DW-1:0]   idx_y,
  input  logic [2*DW-1:0]   idx_sp,
  input  logic [DW-1:0]     acc_a,
  input  logic [DW-1:0]     acc_b,
  output logic              mem_rd_req,
  output logic [2*DW-1:0]   mem_addr,
  input  logic              mem_rd_ack,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              ea_valid,
  output logic [2*DW-1:0]   ea,
  output logic              illegal,
  output logic              wb_en,
  output logic [1:0]        wb_sel,
  output logic [2*DW-1:0]   wb_val
);
  localparam int AW = 2 * DW;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} st_t;
  st_t st;

  logic [AW-1:0] base, step, upd, addr_c, ptr;
  logic [DW-1:0] hi_q;
  logic          is_ind, is_none, is_bad;

  always_comb begin
    case (idx_sel)
      2'b00:   base = idx_x;
      2'b01:   base = idx_y;
      default: base = idx_sp;
    endcase
  end

  assign step = {{(AW-4){opnd[3]}}, opnd[3:0]};
  assign upd  = base + step;

  always_comb begin
    case (mode)
      4'b0001: addr_c = {{DW{1'b0}}, opnd[DW-1:0]};
      4'b0010: addr_c = opnd;
      4'b0011: addr_c = base;
      4'b0100: addr_c = base + {{(AW-9){opnd[8]}}, opnd[8:0]};
      4'b0101: addr_c = base + opnd;
      4'b0110: addr_c = opnd[4] ? upd : base;
      4'b0111: addr_c = base + {{DW{1'b0}}, acc_a};
      4'b1000: addr_c = base + {{DW{1'b0}}, acc_b};
      4'b1010: addr_c = base + opnd;
      4'b1011: addr_c = base + {acc_a, acc_b};
      default: addr_c = '0;
    endcase
  end

  assign is_ind  = (mode == 4'b1010) || (mode == 4'b1011);
  assign is_none = (mode == 4'b0000) || (mode == 4'b1100);
  assign is_bad  = (mode == 4'b1001) || (mode >= 4'b1101);

  assign busy       = (st != S_IDLE);
  assign mem_rd_req = busy;
  assign mem_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      hi_q     <= '0;
      ea       <= '0;
      ea_valid <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      wb_en    <= 1'b0;
      wb_sel   <= '0;
      wb_val   <= '0;
    end else begin
      done     <= 1'b0;
      ea_valid <= 1'b0;
      illegal  <= 1'b0;
      wb_en    <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (is_ind) begin
            ptr <= addr_c;
            st  <= S_HI;
          end else if (is_bad) begin
            done    <= 1'b1;
            illegal <= 1'b1;
          end else if (is_none) begin
            done <= 1'b1;
          end else begin
            done     <= 1'b1;
            ea_valid <= 1'b1;
            ea       <= addr_c;
            if (mode == 4'b0110) begin
              wb_en  <= 1'b1;
              wb_sel <= idx_sel;
              wb_val <= upd;
            end
          end
        end
        S_HI: if (mem_rd_ack) begin
          hi_q <= mem_rd_data;
          ptr  <= ptr + 1'b1;
          st   <= S_LO;
        end
        S_LO: if (mem_rd_ack) begin
          ea       <= {hi_q, mem_rd_data};
          ea_valid <= 1'b1;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  mode,
  input logic        busy,
  input logic        done,
  input logic        ea_valid,
  input logic        illegal,
  input logic        wb_en,
  input logic        mem_rd_req,
  input logic        mem_rd_ack,
  input logic [15:0] mem_addr
);
  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_addr));

  a_r7_illegal_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && !ea_valid && !wb_en);

  a_r2_no_address_modes: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (mode == 4'b0000 || mode == 4'b1100) |=> done && !ea_valid && !mem_rd_req);

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !(mode == 4'b1010 || mode == 4'b1011) |=> done && !busy);

  a_r5_wb_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ea_valid && done);

  a_r6_indirect_starts_read: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (mode == 4'b1010 || mode == 4'b1011) |=> mem_rd_req && !done);

  a_r8_valid_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> done);
endmodule

bind ea_unit ea_unit_chk u_chk (.*);

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] opnd = '0;
  logic [1:0]  idx_sel = '0;
  logic [15:0] idx_x = '0, idx_y = '0, idx_sp = '0;
  logic [7:0]  acc_a = '0, acc_b = '0;
  logic        mem_rd_req, mem_rd_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rd_data;
  logic        busy, done, ea_valid, illegal, wb_en;
  logic [15:0] ea, wb_val;
  logic [1:0]  wb_sel;
  logic        stall = 1'b0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign mem_rd_ack  = mem_rd_req & ~stall;
  assign mem_rd_data = mbyte(mem_addr);

  ea_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] base_of(input logic [1:0] s);
    return (s == 2'b00) ? idx_x : (s == 2'b01) ? idx_y : idx_sp;
  endfunction

  task automatic run_one(input logic [3:0] m);
    logic [15:0] b, st, nv, exp_ea, p;
    logic ind, bad, none;
    b  = base_of(idx_sel);
    st = {{12{opnd[3]}}, opnd[3:0]};
    nv = b + st;
    ind  = (m == 4'hA) || (m == 4'hB);
    bad  = (m == 4'h9) || (m >= 4'hD);
    none = (m == 4'h0) || (m == 4'hC);
    case (m)
      4'h1: exp_ea = {8'h00, opnd[7:0]};
      4'h2: exp_ea = opnd;
      4'h3: exp_ea = b;
      4'h4: exp_ea = b + {{7{opnd[8]}}, opnd[8:0]};
      4'h5: exp_ea = b + opnd;
      4'h6: exp_ea = opnd[4] ? nv : b;
      4'h7: exp_ea = b + {8'h00, acc_a};
      4'h8: exp_ea = b + {8'h00, acc_b};
      default: exp_ea = 16'h0;
    endcase
    p = (m == 4'hA) ? b + opnd : b + {acc_a, acc_b};
    mode = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (ind) begin
      chk("R6 first read req", mem_rd_req, 1);
      chk("R6 high byte addr", mem_addr, p);
      @(negedge clk);
      chk("R6 low byte addr", mem_addr, p + 16'd1);
      @(negedge clk);
      chk("R6 done", done, 1);
      chk("R6 valid", ea_valid, 1);
      chk("R6 pointer", ea, {mbyte(p), mbyte(p + 16'd1)});
      chk("R5 no wb in indirect", wb_en, 0);
    end else begin
      chk("R8 done after one edge", done, 1);
      chk("R8 no memory req", mem_rd_req, 0);
      if (bad) begin
        chk("R7 illegal", illegal, 1);
        chk("R7 no valid", ea_valid, 0);
        chk("R7 no wb", wb_en, 0);
      end else if (none) begin
        chk("R2 no valid for imm/inh", ea_valid, 0);
        chk("R2 no illegal", illegal, 0);
        chk("R2 no wb", wb_en, 0);
      end else begin
        chk("R3 R4 valid", ea_valid, 1);
        chk("R2 R3 R4 R5 address", ea, exp_ea);
        chk("R7 no illegal", illegal, 0);
        chk("R5 wb enable", wb_en, (m == 4'h6));
        if (m == 4'h6) begin
          chk("R5 wb value", wb_val, nv);
          chk("R5 wb select", wb_sel, idx_sel);
        end
      end
    end
    @(negedge clk);
    chk("R5 R8 done is one pulse", {done, wb_en}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset outputs", {done, ea_valid, illegal, wb_en, busy, mem_rd_req}, 0);
    chk("R1 reset ea", ea, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 24; k++) begin
      for (int s = 0; s < 4; s++) begin
        for (int m = 0; m < 16; m++) begin
          idx_x = $urandom; idx_y = $urandom; idx_sp = $urandom;
          acc_a = $urandom; acc_b = $urandom; opnd = $urandom;
          if (k == 0) begin idx_x = 16'hFFFF; idx_y = 16'hFFFF; idx_sp = 16'hFFFF; opnd = 16'h01FF; acc_a = 8'hFF; acc_b = 8'hFF; end
          if (k == 1) begin idx_x = 16'h0000; idx_y = 16'h0000; idx_sp = 16'h0000; opnd = 16'h0018; end
          if (k == 2) begin idx_x = 16'hFFFE; idx_y = 16'hFFFE; idx_sp = 16'hFFFE; opnd = 16'h0007; end
          idx_sel = s[1:0];
          run_one(m[3:0]);
        end
      end
    end

    idx_sel = 2'b01; idx_y = 16'h1234; opnd = 16'h0100;
    mode = 4'hA; start = 1'b1; stall = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode = 4'h2; start = 1'b1;
    @(negedge clk);
    chk("R8 start ignored while busy", done, 0);
    start = 1'b0;
    @(negedge clk);
    chk("R6 address held under stall", mem_addr, 16'h1334);
    stall = 1'b0;
    @(negedge clk);
    chk("R6 no valid after one byte", ea_valid, 0);
    @(negedge clk);
    chk("R6 stalled result", ea, {mbyte(16'h1334), mbyte(16'h1335)});
    chk("R6 stalled valid", ea_valid, 1);
    @(negedge clk);
    chk("R8 no extra completion", done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule